// File: doc/BRIEF.md
# Multi-Format Audio Serial Data Port

This block moves one left and one right audio sample per frame between parallel sample registers and a four-wire serial audio bus: bit clock, word clock, serial data in and serial data out. The bit and word clocks are inputs, whether they come from another device or from a clock generator elsewhere on the chip. A fast system clock oversamples them. All data is sent most significant bit first.

One frame engine covers five framings: left-justified, right-justified, I2S, DSP and TDM. Telephony PCM is carried in TDM. The sample width is selectable. A start offset places the samples inside a DSP or TDM frame. When bits carry no data, the output enable can be dropped, so that several ports can share one data wire.

The engine is a state machine with four states:
- ST_OFF: powered down.
- ST_HUNT: waiting for the first frame start.
- ST_LEFT: the left slot.
- ST_RIGHT: the right slot.

Its transitions are evaluated at each bit-clock falling edge:
- wake (ST_OFF to ST_HUNT): the port is no longer powered down.
- lock (ST_HUNT to ST_LEFT): a frame-start edge arrives.
- restart (ST_LEFT or ST_RIGHT to ST_LEFT): a frame-start edge arrives.
- swap (ST_LEFT to ST_RIGHT): in the half-frame formats, the opposite word-clock edge arrives. In DSP and TDM, the position reaches the start of the right window.
- sleep (any state to ST_OFF): power-down is asserted. This transition does not wait for a bit-clock edge.

Top module: `audio_serial_port`

## Requirements
- R1: With fmt=0 (left-justified), the frame starts on a rising word-clock edge. The left half runs while the word clock is high and the right half while it is low. Each sample's MSB is on the first bit clock of its half. width_sel picks 16, 20, 24 or 32 bits (codes 0, 1, 2, 3).
- R2: With fmt=2 (I2S), the frame starts on a falling word-clock edge, and the left half runs while the word clock is low. Each sample's MSB sits one bit clock after the word-clock transition.
- R3: With fmt=1 (right-justified), the left half runs while the word clock is high. Each sample's LSB sits on bit clock half_len-1 of its half, where counting starts at 0 from the word-clock transition.
- R4: With fmt=3 (DSP), a word-clock pulse marks the frame start, and that pulse bit clock is position 0. The left MSB is at position 1+start_off, and the right sample follows with no gap.
- R5: With fmt=4 (TDM), the left MSB is at position start_off and the right sample follows with no gap. When hiz_idle=1, sdout_oe is low on every bit clock without data. When hiz_idle=0, sdout_oe stays high there and sdout is 0.
- R6: Receive bits are sampled on the bit-clock rising edge, in the same windows as transmit. Samples appear right-aligned on rx_left and rx_right, with a one-cycle rx_valid after the last right bit. Bits outside the windows are ignored.
- R7: While pwr_dn=1, sdout_oe is 0 and no rx_valid is produced.
- R8: Until the first frame-start edge after power-up, no data is sent: sdout is 0, sdout_oe equals !hiz_idle, and no rx_valid occurs.
- R9: tx_left and tx_right are captured at the frame start. A change during the frame has no effect until the next frame.
- R10: After reset, sdout, sdout_oe and rx_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset |
| pwr_dn | input | 1 | Power-down; the output is released |
| fmt | input | 3 | Framing: 0 LJ, 1 RJ, 2 I2S, 3 DSP, 4 TDM |
| width_sel | input | 2 | Sample width: 16, 20, 24, 32 bits |
| start_off | input | 8 | Data start offset in DSP/TDM frames |
| half_len | input | 8 | Bit clocks per half frame (used by RJ) |
| hiz_idle | input | 1 | Drop the output enable on bits without data |
| bclk | input | 1 | Serial bit clock |
| wclk | input | 1 | Serial word clock |
| sdin | input | 1 | Serial data in |
| sdout | output | 1 | Serial data out |
| sdout_oe | output | 1 | Output enable for sdout |
| tx_left | input | 32 | Left sample to send, right-aligned |
| tx_right | input | 32 | Right sample to send, right-aligned |
| rx_left | output | 32 | Received left sample, right-aligned |
| rx_right | output | 32 | Received right sample, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for a received pair |

## Verification
A bus edge takes two synchronizer stages and one edge-detect cycle to register. sdout and sdout_oe therefore change three system clocks after the bit-clock fall that launches a bit, and rx_valid rises three clocks after the rise that carries the last right bit. The bench holds each bit-clock phase for six system clocks. It checks the output in the last cycle of the low phase, well after the update and before the next rise. The receive monitor compares each rx_valid pulse, as it occurs, against the expected pair queued when the frame was driven.

// File: rtl/asp_pkg.sv
package asp_pkg;
    localparam int POS_W = 9;
    localparam int WMAX  = 32;
    localparam int XW    = POS_W + 2;

    typedef enum logic [2:0] {FMT_LJ = 3'd0, FMT_RJ = 3'd1, FMT_I2S = 3'd2,
                              FMT_DSP = 3'd3, FMT_TDM = 3'd4} fmt_e;
    typedef enum logic [1:0] {ST_OFF, ST_HUNT, ST_LEFT, ST_RIGHT} st_e;
    typedef struct packed {
        logic       hit;
        logic [4:0] idx;
    } slot_t;

    function automatic logic [5:0] width_of(input logic [1:0] sel);
        case (sel)
            2'd0:    return 6'd16;
            2'd1:    return 6'd20;
            2'd2:    return 6'd24;
            default: return 6'd32;
        endcase
    endfunction

    // Window start of the current slot and bit index at a frame position
    function automatic slot_t slot_of(input fmt_e f, input st_e s, input logic [POS_W-1:0] pos,
                                      input logic [5:0] w, input logic [7:0] off,
                                      input logic [7:0] hl);
        logic [XW-1:0] st, wx, ox, hx, px;
        slot_t r;
        wx = XW'(w);
        ox = XW'(off);
        hx = XW'(hl);
        px = XW'(pos);
        case (f)
            FMT_LJ:  st = '0;
            FMT_I2S: st = XW'(1);
            FMT_RJ:  st = (hx >= wx) ? hx - wx : '0;
            FMT_DSP: st = ox + XW'(1) + ((s == ST_RIGHT) ? wx : '0);
            FMT_TDM: st = ox + ((s == ST_RIGHT) ? wx : '0);
            default: st = '0;
        endcase
        r.hit = (s == ST_LEFT || s == ST_RIGHT) && (px >= st) && (px < st + wx);
        r.idx = 5'(wx - XW'(1) - (px - st));
        return r;
    endfunction
endpackage

// File: rtl/asp_edge.sv
module asp_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic wclk,
    input  logic sdin,
    output logic rise_ev,
    output logic fall_ev,
    output logic wclk_s,
    output logic sdin_s
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] sync_b, sync_w, sync_d;
    logic         b_prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_b <= '0;
                    sync_w <= '0;
                    sync_d <= '0;
                end else begin
                    sync_b <= bclk;
                    sync_w <= wclk;
                    sync_d <= sdin;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_b <= '0;
                    sync_w <= '0;
                    sync_d <= '0;
                end else begin
                    sync_b <= {sync_b[TOP-1:0], bclk};
                    sync_w <= {sync_w[TOP-1:0], wclk};
                    sync_d <= {sync_d[TOP-1:0], sdin};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_prev <= 1'b0;
        else        b_prev <= sync_b[TOP];
    end

    assign rise_ev = sync_b[TOP] & ~b_prev;
    assign fall_ev = ~sync_b[TOP] & b_prev;
    assign wclk_s  = sync_w[TOP];
    assign sdin_s  = sync_d[TOP];

    assert_rise_spaced_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_ev |=> !rise_ev);
endmodule

// File: rtl/asp_frame_fsm.sv
module asp_frame_fsm
    import asp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_dn,
    input  logic             fall_ev,
    input  logic             wclk_s,
    input  fmt_e             fmt,
    input  logic [5:0]       w,
    input  logic [7:0]       off,
    output st_e              st_q,
    output st_e              st_nx,
    output logic [POS_W-1:0] pos_q,
    output logic [POS_W-1:0] pos_nx,
    output logic             fstart
);
    logic             wclk_last;
    logic             w_rise, w_fall, fs_edge, op_edge, half_fmt;
    logic [POS_W-1:0] pos_inc;
    logic [XW-1:0]    bound;

    assign w_rise   = wclk_s & ~wclk_last;
    assign w_fall   = ~wclk_s & wclk_last;
    assign fs_edge  = (fmt == FMT_I2S) ? w_fall : w_rise;
    assign op_edge  = (fmt == FMT_I2S) ? w_rise : w_fall;
    assign half_fmt = (fmt == FMT_LJ) || (fmt == FMT_RJ) || (fmt == FMT_I2S);
    assign pos_inc  = (pos_q == '1) ? pos_q : pos_q + POS_W'(1);
    assign bound    = XW'(off) + XW'(w) + ((fmt == FMT_DSP) ? XW'(1) : '0);

    always_comb begin
        st_nx  = st_q;
        pos_nx = pos_q;
        fstart = 1'b0;
        if (pwr_dn) begin
            st_nx = ST_OFF;
        end else if (fall_ev) begin
            unique case (st_q)
                ST_OFF: st_nx = ST_HUNT;
                ST_HUNT: begin
                    if (fs_edge) begin
                        st_nx  = ST_LEFT;
                        pos_nx = '0;
                        fstart = 1'b1;
                    end
                end
                ST_LEFT: begin
                    if (fs_edge) begin
                        pos_nx = '0;
                        fstart = 1'b1;
                    end else if (half_fmt && op_edge) begin
                        st_nx  = ST_RIGHT;
                        pos_nx = '0;
                    end else begin
                        pos_nx = pos_inc;
                        if (!half_fmt && XW'(pos_inc) == bound) st_nx = ST_RIGHT;
                    end
                end
                ST_RIGHT: begin
                    if (fs_edge) begin
                        st_nx  = ST_LEFT;
                        pos_nx = '0;
                        fstart = 1'b1;
                    end else begin
                        pos_nx = pos_inc;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= ST_OFF;
            pos_q     <= '1;
            wclk_last <= 1'b0;
        end else begin
            st_q  <= st_nx;
            pos_q <= pos_nx;
            if (fall_ev) wclk_last <= wclk_s;
        end
    end

    assert_pd_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> st_q == ST_OFF);
    assert_hunt_no_right_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_HUNT |=> st_q != ST_RIGHT);
endmodule

// File: rtl/asp_tx.sv
module asp_tx
    import asp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_dn,
    input  logic             fall_ev,
    input  logic             fstart,
    input  st_e              st_nx,
    input  logic [POS_W-1:0] pos_nx,
    input  fmt_e             fmt,
    input  logic [5:0]       w,
    input  logic [7:0]       off,
    input  logic [7:0]       hl,
    input  logic             hiz_idle,
    input  logic [WMAX-1:0]  tx_l,
    input  logic [WMAX-1:0]  tx_r,
    output logic             sd,
    output logic             sd_oe
);
    logic [WMAX-1:0] hold_l, hold_r, word;
    slot_t           sl;

    assign sl   = slot_of(fmt, st_nx, pos_nx, w, off, hl);
    assign word = fstart ? tx_l : ((st_nx == ST_RIGHT) ? hold_r : hold_l);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_l <= '0;
            hold_r <= '0;
            sd     <= 1'b0;
            sd_oe  <= 1'b0;
        end else if (pwr_dn) begin
            sd    <= 1'b0;
            sd_oe <= 1'b0;
        end else if (fall_ev) begin
            if (fstart) begin
                hold_l <= tx_l;
                hold_r <= tx_r;
            end
            if (sl.hit) begin
                sd    <= word[sl.idx];
                sd_oe <= 1'b1;
            end else begin
                sd    <= 1'b0;
                sd_oe <= ~hiz_idle;
            end
        end
    end

    assert_pd_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> !sd_oe);
    assert_hunt_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_ev && !pwr_dn && st_nx == ST_HUNT) |=> !sd);
endmodule

// File: rtl/asp_rx.sv
module asp_rx
    import asp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_ev,
    input  logic             sdin_s,
    input  st_e              st_q,
    input  logic [POS_W-1:0] pos_q,
    input  fmt_e             fmt,
    input  logic [5:0]       w,
    input  logic [7:0]       off,
    input  logic [7:0]       hl,
    output logic [WMAX-1:0]  rx_l,
    output logic [WMAX-1:0]  rx_r,
    output logic             rx_v
);
    logic [WMAX-1:0] sh_l, sh_r, cur, nxt;
    slot_t           sl;
    logic            first;

    assign sl    = slot_of(fmt, st_q, pos_q, w, off, hl);
    assign first = (sl.idx == 5'(w - 6'd1));
    assign cur   = (st_q == ST_RIGHT) ? sh_r : sh_l;
    assign nxt   = first ? {{(WMAX-1){1'b0}}, sdin_s} : {cur[WMAX-2:0], sdin_s};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_l <= '0;
            sh_r <= '0;
            rx_l <= '0;
            rx_r <= '0;
            rx_v <= 1'b0;
        end else begin
            rx_v <= 1'b0;
            if (rise_ev && sl.hit) begin
                if (st_q == ST_RIGHT) begin
                    sh_r <= nxt;
                    if (sl.idx == 5'd0) begin
                        rx_l <= sh_l;
                        rx_r <= nxt;
                        rx_v <= 1'b1;
                    end
                end else begin
                    sh_l <= nxt;
                end
            end
        end
    end

    assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_v |=> !rx_v);
    assert_valid_after_right_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_v |-> $past(st_q) == ST_RIGHT);
endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port
    import asp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pwr_dn,
    input  logic [2:0]  fmt,
    input  logic [1:0]  width_sel,
    input  logic [7:0]  start_off,
    input  logic [7:0]  half_len,
    input  logic        hiz_idle,
    input  logic        bclk,
    input  logic        wclk,
    input  logic        sdin,
    output logic        sdout,
    output logic        sdout_oe,
    input  logic [31:0] tx_left,
    input  logic [31:0] tx_right,
    output logic [31:0] rx_left,
    output logic [31:0] rx_right,
    output logic        rx_valid
);
    fmt_e             f;
    logic [5:0]       w;
    logic             rise_ev, fall_ev, wclk_s, sdin_s, fstart;
    st_e              st_q, st_nx;
    logic [POS_W-1:0] pos_q, pos_nx;

    assign f = fmt_e'(fmt);
    assign w = width_of(width_sel);

    asp_edge #(.STAGES(2)) u_edge (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .wclk(wclk), .sdin(sdin),
        .rise_ev(rise_ev), .fall_ev(fall_ev), .wclk_s(wclk_s), .sdin_s(sdin_s));

    asp_frame_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .fall_ev(fall_ev), .wclk_s(wclk_s),
        .fmt(f), .w(w), .off(start_off), .st_q(st_q), .st_nx(st_nx),
        .pos_q(pos_q), .pos_nx(pos_nx), .fstart(fstart));

    asp_tx u_tx (
        .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .fall_ev(fall_ev), .fstart(fstart),
        .st_nx(st_nx), .pos_nx(pos_nx), .fmt(f), .w(w), .off(start_off), .hl(half_len),
        .hiz_idle(hiz_idle), .tx_l(tx_left), .tx_r(tx_right), .sd(sdout), .sd_oe(sdout_oe));

    asp_rx u_rx (
        .clk(clk), .rst_n(rst_n), .rise_ev(rise_ev), .sdin_s(sdin_s), .st_q(st_q),
        .pos_q(pos_q), .fmt(f), .w(w), .off(start_off), .hl(half_len),
        .rx_l(rx_left), .rx_r(rx_right), .rx_v(rx_valid));
endmodule

// File: tb/audio_serial_port_test.sv
module audio_serial_port_test;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_dn = 1'b1;
    logic [2:0]  fmt = 3'd0;
    logic [1:0]  width_sel = 2'd0;
    logic [7:0]  start_off = 8'd0;
    logic [7:0]  half_len = 8'd16;
    logic        hiz_idle = 1'b0;
    logic        bclk = 1'b1;
    logic        wclk = 1'b0;
    logic        sdin = 1'b0;
    logic        sdout, sdout_oe, rx_valid;
    logic [31:0] tx_left = '0, tx_right = '0, rx_left, rx_right;

    int          n_chk = 0;
    int          n_err = 0;
    int          rx_seen = 0;
    bit          done = 0;
    logic [63:0] expq[$];
    logic [63:0] exp_pair;

    always #10 clk = ~clk;

    audio_serial_port uut (
        .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .fmt(fmt), .width_sel(width_sel),
        .start_off(start_off), .half_len(half_len), .hiz_idle(hiz_idle), .bclk(bclk),
        .wclk(wclk), .sdin(sdin), .sdout(sdout), .sdout_oe(sdout_oe), .tx_left(tx_left),
        .tx_right(tx_right), .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid));

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    // Monitor: pop and compare each received pair as it appears
    always @(negedge clk) begin
        if (rx_valid) begin
            rx_seen++;
            if (expq.size() > 0) begin
                exp_pair = expq.pop_front();
                chk({rx_left, rx_right} == exp_pair, "R6 receive pair", {rx_left, rx_right}, exp_pair);
            end
        end
    end

    function automatic int wid();
        return (width_sel == 2'd0) ? 16 : (width_sel == 2'd1) ? 20 : (width_sel == 2'd2) ? 24 : 32;
    endfunction

    function automatic void model(input int p, output bit hit, output bit right, output int idx);
        int w, hl, q, st, ls;
        w  = wid();
        hl = int'(half_len);
        if (fmt <= 3'd2) begin
            right = (p >= hl);
            q     = right ? p - hl : p;
            st    = (fmt == 3'd0) ? 0 : (fmt == 3'd2) ? 1 : ((hl >= w) ? hl - w : 0);
        end else begin
            ls    = (fmt == 3'd3) ? 1 + int'(start_off) : int'(start_off);
            right = (p >= ls + w);
            q     = p;
            st    = right ? ls + w : ls;
        end
        hit = (q >= st) && (q < st + w);
        idx = w - 1 - (q - st);
    endfunction

    function automatic bit wlevel(input int p);
        int hl;
        hl = int'(half_len);
        if (fmt == 3'd0 || fmt == 3'd1) return p < hl;
        if (fmt == 3'd2) return p >= hl;
        return p == 0;
    endfunction

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) bclk = 1'b0;
            repeat (HALF - 1) @(negedge clk);
            @(negedge clk) bclk = 1'b1;
            repeat (HALF - 1) @(negedge clk);
        end
    endtask

    // Driver: drives one frame, checks each output bit, queues the expected receive pair
    task automatic run_frame(input int fl, input bit check, input logic [31:0] tl, input logic [31:0] tr,
                             input logic [31:0] rl, input logic [31:0] rr, input bit chg, input string rq);
        logic [31:0] msk;
        bit          hit, right, exp_oe, exp_sd, din;
        int          idx;
        msk      = 32'((64'd1 << wid()) - 64'd1);
        tx_left  = tl;
        tx_right = tr;
        if (check && !pwr_dn) expq.push_back({rl & msk, rr & msk});
        for (int p = 0; p < fl; p++) begin
            model(p, hit, right, idx);
            din = hit ? (right ? rr[idx] : rl[idx]) : 1'b1;
            @(negedge clk);
            bclk = 1'b0;
            wclk = wlevel(p);
            sdin = din;
            repeat (HALF - 1) @(negedge clk);
            if (check) begin
                exp_oe = pwr_dn ? 1'b0 : (hit ? 1'b1 : !hiz_idle);
                exp_sd = (pwr_dn || !hit) ? 1'b0 : (right ? tr[idx] : tl[idx]);
                chk(sdout_oe == exp_oe && sdout == exp_sd, rq, {sdout_oe, sdout}, {exp_oe, exp_sd});
            end
            if (chg && p == fl / 4) tx_left = ~tl;
            @(negedge clk) bclk = 1'b1;
            repeat (HALF - 1) @(negedge clk);
        end
    endtask

    task automatic scenario(input logic [2:0] f, input logic [1:0] ws, input int off, input int hl,
                            input int fl, input bit hz, input bit chg, input string rq);
        fmt       = f;
        width_sel = ws;
        start_off = 8'(off);
        half_len  = 8'(hl);
        hiz_idle  = hz;
        run_frame(fl, 0, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 0, rq);
        run_frame(fl, 1, 32'hC3A5_96E1, 32'h5A69_3C87, 32'h8E4D_B217, 32'h71B2_4DE8, chg, rq);
        run_frame(fl, 1, 32'h2B7F_D04C, 32'hE480_1FB3, 32'hA55A_C33C, 32'h3CC3_5AA5, 0, rq);
        chk(expq.size() == 0, {rq, " R6 pair delivered"}, 64'(expq.size()), 64'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog R10 actual=running expected=finished");
        finish_up();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(sdout == 0 && sdout_oe == 0 && rx_valid == 0, "R10 reset state",
            {sdout, sdout_oe, rx_valid}, 0);

        // R8: powered up but no frame edge yet
        pwr_dn   = 1'b0;
        fmt      = 3'd0;
        hiz_idle = 1'b0;
        sdin     = 1'b1;
        tick(6);
        chk(sdout_oe == 1 && sdout == 0, "R8 hunt drives zero", {sdout_oe, sdout}, 2'b10);
        chk(rx_seen == 0, "R8 hunt no strobe", rx_seen, 0);
        hiz_idle = 1'b1;
        tick(2);
        chk(sdout_oe == 0, "R8 hunt released", sdout_oe, 0);

        scenario(3'd0, 2'd0, 0, 16, 32, 0, 0, "R1 LJ 16");
        scenario(3'd0, 2'd3, 0, 32, 64, 1, 0, "R1 LJ 32");
        scenario(3'd0, 2'd1, 0, 32, 64, 0, 0, "R1 LJ 20");
        scenario(3'd0, 2'd2, 0, 32, 64, 1, 1, "R9 LJ 24 midframe change");
        scenario(3'd2, 2'd2, 0, 32, 64, 0, 0, "R2 I2S 24");
        scenario(3'd2, 2'd0, 0, 32, 64, 1, 0, "R2 I2S 16");
        scenario(3'd1, 2'd0, 0, 32, 64, 0, 0, "R3 RJ 16");
        scenario(3'd1, 2'd1, 0, 24, 48, 1, 0, "R3 RJ 20");
        scenario(3'd3, 2'd0, 0, 16, 40, 1, 0, "R4 DSP off 0");
        scenario(3'd3, 2'd1, 3, 16, 64, 0, 0, "R4 DSP off 3");
        scenario(3'd4, 2'd0, 32, 16, 128, 1, 0, "R5 TDM hiz");
        scenario(3'd4, 2'd3, 5, 16, 80, 0, 0, "R5 TDM driven idle");

        // R7: power-down releases the line and stops reception
        pwr_dn = 1'b1;
        rx_seen = 0;
        fmt = 3'd0;
        width_sel = 2'd0;
        half_len = 8'd16;
        hiz_idle = 1'b0;
        run_frame(32, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1111_2222, 32'h3333_4444, 0, "R7 powered down");
        run_frame(32, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1111_2222, 32'h3333_4444, 0, "R7 powered down");
        chk(rx_seen == 0, "R7 no strobe while down", rx_seen, 0);

        finish_up();
    end
endmodule